// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives the bit timing of a CAN node from the system clock. A prescaler divides the clock into time quanta. A segment engine builds each bit from one synchronisation quantum and two programmable phase segments. It then issues a sample strobe at the end of the first phase segment and a boundary strobe at the end of the bit. It also captures the bus level at the sample point, either as a single sample or as a majority of three consecutive quanta. Falling edges on the bus resynchronise the bit, within a bounded jump.

The timing fields can only be changed under a handshake. Software raises a change request and waits for the change-enable flag. It then writes the prescaler, both segment lengths, the jump width and the sampling mode. Finally it drops the request and waits for the flag to clear. The new timing starts with the first bit after the flag clears.

Top module: `can_bit_timing`

## Requirements
- R1: A time quantum lasts BRP+1 clock cycles, and a bit without resynchronisation lasts (BRP+1)*((TSEG1+1)+(TSEG2+1)+1) cycles.
- R2: After reset, `chg_en_o` is 0 and `rx_bit_o` is 1. The reset timing is BRP=2, TSEG1=4, TSEG2=3, SJW=0 and single sampling, which gives 30 cycles per bit (500 kbit/s from 15 MHz).
- R3: `chg_en_o` is updated only on the clock edge that ends a cycle in which `bit_end_o` is high, and it takes the value that `chg_req_i` has in that cycle.
- R4: A write pulse on `wr_en_i` while `chg_en_o` is 0 has no effect on the timing.
- R5: Written timing fields take effect from the first bit that starts after `chg_en_o` falls.
- R6: `sample_o` is high in the last clock cycle of the first phase segment, (BRP+1)*(TSEG1+2) cycles after the `bit_end_o` cycle of the previous bit. It is never high in the same cycle as `bit_end_o`.
- R7: In single mode (triple select 0), `rx_bit_o` takes the value of `rx_i` at the sample tick, one cycle after `sample_o`, and holds it otherwise.
- R8: In triple mode (triple select 1), `rx_bit_o` takes the majority of `rx_i` at the ticks that end the sample quantum and the two quanta before it.
- R9: A 1-to-0 transition of `rx_i` seen at the tick ending quantum k (0-based) of the first phase segment lengthens that segment by min(k+1, SJW+1) quanta.
- R10: A 1-to-0 transition seen in the second phase segment ends the bit at the later of two points: the current quantum, or SJW+1 quanta before the nominal end.
- R11: A transition seen during the sync quantum has no effect, and a bit is resynchronised at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chg_req_i | input | 1 | Configuration change request (level) |
| wr_en_i | input | 1 | Write strobe for the timing fields |
| wr_brp_i | input | BRP_W | Prescaler value to write |
| wr_tseg1_i | input | T1_W | First phase segment length minus one |
| wr_tseg2_i | input | T2_W | Second phase segment length minus one |
| wr_sjw_i | input | SJW_W | Jump width minus one |
| wr_triple_i | input | 1 | 1 selects three-sample majority |
| rx_i | input | 1 | Bus receive level, 1 recessive |
| chg_en_o | output | 1 | Change enable, timing fields writable |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Bit-boundary strobe |
| rx_bit_o | output | 1 | Sampled bus level |

## Verification
The properties assume that `chg_req_i` is a level that software holds until `chg_en_o` answers it. They also assume that `rx_i` is a synchronous signal, so an edge is seen at exactly one quantum tick. The stimulus changes every input half a cycle after the active edge. It holds the request until the acknowledge shows, and it places each bus edge on a chosen quantum. This ties the expected resynchronisation length to a single segment position.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {SEG_SYNC, SEG_TS1, SEG_TS2} seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_cfg.sv
module cbt_cfg #(
  parameter int BRP_W   = 6,
  parameter int T1_W    = 4,
  parameter int T2_W    = 3,
  parameter int SJW_W   = 2,
  parameter int BRP_RST = 2,
  parameter int T1_RST  = 4,
  parameter int T2_RST  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_req_i,
  input  logic             wr_en_i,
  input  logic [BRP_W-1:0] wr_brp_i,
  input  logic [T1_W-1:0]  wr_tseg1_i,
  input  logic [T2_W-1:0]  wr_tseg2_i,
  input  logic [SJW_W-1:0] wr_sjw_i,
  input  logic             wr_triple_i,
  input  logic             bit_end_i,
  output logic             chg_en_o,
  output logic [BRP_W-1:0] brp_o,
  output logic [T1_W-1:0]  tseg1_o,
  output logic [T2_W-1:0]  tseg2_o,
  output logic [SJW_W-1:0] sjw_o,
  output logic             triple_o
);
  logic             chg_en_q;
  logic [BRP_W-1:0] stg_brp_q, act_brp_q;
  logic [T1_W-1:0]  stg_t1_q, act_t1_q;
  logic [T2_W-1:0]  stg_t2_q, act_t2_q;
  logic [SJW_W-1:0] stg_sjw_q, act_sjw_q;
  logic             stg_tri_q, act_tri_q;
  logic             commit;

  assign commit = bit_end_i & chg_en_q & ~chg_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_en_q  <= 1'b0;
      stg_brp_q <= BRP_W'(BRP_RST);
      stg_t1_q  <= T1_W'(T1_RST);
      stg_t2_q  <= T2_W'(T2_RST);
      stg_sjw_q <= '0;
      stg_tri_q <= 1'b0;
      act_brp_q <= BRP_W'(BRP_RST);
      act_t1_q  <= T1_W'(T1_RST);
      act_t2_q  <= T2_W'(T2_RST);
      act_sjw_q <= '0;
      act_tri_q <= 1'b0;
    end else begin
      if (bit_end_i) chg_en_q <= chg_req_i;
      if (wr_en_i && chg_en_q) begin
        stg_brp_q <= wr_brp_i;
        stg_t1_q  <= wr_tseg1_i;
        stg_t2_q  <= wr_tseg2_i;
        stg_sjw_q <= wr_sjw_i;
        stg_tri_q <= wr_triple_i;
      end
      // shadow copy lands on the boundary where enable drops
      if (commit) begin
        act_brp_q <= stg_brp_q;
        act_t1_q  <= stg_t1_q;
        act_t2_q  <= stg_t2_q;
        act_sjw_q <= stg_sjw_q;
        act_tri_q <= stg_tri_q;
      end
    end
  end

  assign chg_en_o = chg_en_q;
  assign brp_o    = act_brp_q;
  assign tseg1_o  = act_t1_q;
  assign tseg2_o  = act_t2_q;
  assign sjw_o    = act_sjw_q;
  assign triple_o = act_tri_q;
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o = (cnt_q == brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + BRP_W'(1);
  end
endmodule

// File: rtl/cbt_bit_engine.sv
module cbt_bit_engine
  import cbt_pkg::*;
#(
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             bit_end_o
);
  localparam int AW = (T1_W > T2_W) ? T1_W : T2_W;
  localparam int QW = ((AW > SJW_W) ? AW : SJW_W) + 2;

  seg_e          seg_q;
  logic [QW-1:0] qcnt_q, last_q, eff_last, sjw1, late, ext;
  logic          rx_prev_q, done_q, edge_w, at_end;

  assign sjw1   = QW'(sjw_i) + QW'(1);
  assign late   = qcnt_q + QW'(1);
  assign ext    = (late < sjw1) ? late : sjw1;
  assign edge_w = tick_i & rx_prev_q & ~rx_i & ~done_q & (seg_q != SEG_SYNC);

  always_comb begin
    eff_last = last_q;
    if (edge_w) begin
      if (seg_q == SEG_TS1)
        eff_last = last_q + ext;
      else if (seg_q == SEG_TS2)
        eff_last = (last_q >= qcnt_q + sjw1) ? last_q - sjw1 : qcnt_q;
    end
  end

  assign at_end    = tick_i & (qcnt_q == eff_last);
  assign sample_o  = at_end & (seg_q == SEG_TS1);
  assign bit_end_o = at_end & (seg_q == SEG_TS2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      last_q    <= '0;
      rx_prev_q <= 1'b1;
      done_q    <= 1'b0;
    end else if (tick_i) begin
      rx_prev_q <= rx_i;
      if (edge_w) done_q <= 1'b1;
      case (seg_q)
        SEG_SYNC: begin
          seg_q  <= SEG_TS1;
          qcnt_q <= '0;
          last_q <= QW'(tseg1_i);
          done_q <= 1'b0;
        end
        SEG_TS1: begin
          if (at_end) begin
            seg_q  <= SEG_TS2;
            qcnt_q <= '0;
            last_q <= QW'(tseg2_i);
          end else begin
            qcnt_q <= qcnt_q + QW'(1);
            last_q <= eff_last;
          end
        end
        SEG_TS2: begin
          if (at_end) begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
          end else begin
            qcnt_q <= qcnt_q + QW'(1);
            last_q <= eff_last;
          end
        end
        default: seg_q <= SEG_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sample_i,
  input  logic triple_i,
  input  logic rx_i,
  output logic rx_bit_o
);
  logic [1:0] hist_q;
  logic       bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
    end else begin
      if (tick_i)   hist_q <= {hist_q[0], rx_i};
      if (sample_i) bit_q  <= triple_i ? maj3(rx_i, hist_q[0], hist_q[1]) : rx_i;
    end
  end

  assign rx_bit_o = bit_q;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int BRP_W   = 6,
  parameter int T1_W    = 4,
  parameter int T2_W    = 3,
  parameter int SJW_W   = 2,
  parameter int BRP_RST = 2,
  parameter int T1_RST  = 4,
  parameter int T2_RST  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_req_i,
  input  logic             wr_en_i,
  input  logic [BRP_W-1:0] wr_brp_i,
  input  logic [T1_W-1:0]  wr_tseg1_i,
  input  logic [T2_W-1:0]  wr_tseg2_i,
  input  logic [SJW_W-1:0] wr_sjw_i,
  input  logic             wr_triple_i,
  input  logic             rx_i,
  output logic             chg_en_o,
  output logic             sample_o,
  output logic             bit_end_o,
  output logic             rx_bit_o
);
  logic [BRP_W-1:0] brp;
  logic [T1_W-1:0]  t1;
  logic [T2_W-1:0]  t2;
  logic [SJW_W-1:0] sjw;
  logic             triple, tick;

  cbt_cfg #(
    .BRP_W(BRP_W), .T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W),
    .BRP_RST(BRP_RST), .T1_RST(T1_RST), .T2_RST(T2_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .chg_req_i, .wr_en_i, .wr_brp_i, .wr_tseg1_i,
    .wr_tseg2_i, .wr_sjw_i, .wr_triple_i,
    .bit_end_i(bit_end_o), .chg_en_o,
    .brp_o(brp), .tseg1_o(t1), .tseg2_o(t2), .sjw_o(sjw), .triple_o(triple)
  );

  cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk_i, .rst_ni, .brp_i(brp), .tick_o(tick)
  );

  cbt_bit_engine #(.T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i, .tseg1_i(t1), .tseg2_i(t2),
    .sjw_i(sjw), .sample_o, .bit_end_o
  );

  cbt_sampler u_smp (
    .clk_i, .rst_ni, .tick_i(tick), .sample_i(sample_o), .triple_i(triple),
    .rx_i, .rx_bit_o
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic chg_req_i,
  input logic chg_en_o,
  input logic sample_o,
  input logic bit_end_o,
  input logic rx_bit_o
);
  assert_rise_at_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_en_o) |-> $past(bit_end_o));

  assert_follow_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> (chg_en_o == $past(chg_req_i)));

  assert_fall_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chg_en_o) |-> $past(bit_end_o));

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_end_o));

  assert_rxbit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_o) |-> $stable(rx_bit_o));
endmodule

bind can_bit_timing cbt_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chg_req_i(chg_req_i), .chg_en_o(chg_en_o),
  .sample_o(sample_o), .bit_end_o(bit_end_o), .rx_bit_o(rx_bit_o)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req = 1'b0, wr = 1'b0, rx = 1'b1, tri_s = 1'b0;
  logic [5:0] brp = '0;
  logic [3:0] t1 = '0;
  logic [2:0] t2 = '0;
  logic [1:0] sjw = '0;
  logic       chg_en, samp, bend, rxb;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  can_bit_timing u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chg_req_i(req), .wr_en_i(wr),
    .wr_brp_i(brp), .wr_tseg1_i(t1), .wr_tseg2_i(t2), .wr_sjw_i(sjw),
    .wr_triple_i(tri_s), .rx_i(rx), .chg_en_o(chg_en), .sample_o(samp),
    .bit_end_o(bend), .rx_bit_o(rxb)
  );

  // brp, tseg1, tseg2
  localparam int NV = 4;
  localparam int VEC [NV][3] = '{'{0, 4, 3}, '{5, 15, 7}, '{2, 4, 3}, '{1, 2, 1}};

  task automatic check(input bit ok, input string req_s, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
    end
  endtask

  task automatic wait_end();
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk); #1;
      if (bend) return;
    end
    check(0, "bit_end timeout", 0, 1);
  endtask

  // waits for a boundary, then counts cycles of the following bit, driving rx at set offsets
  task automatic run_bit(input int d1, input logic v1, input int d2, input logic v2,
                         input int d3, input logic v3, input int rd,
                         output int ts, output int te, output logic bv);
    wait_end();
    ts = -1; te = -1; bv = 1'bx;
    for (int c = 1; c < 5000; c++) begin
      @(negedge clk);
      if (c == d1) rx = v1;
      if (c == d2) rx = v2;
      if (c == d3) rx = v3;
      #1;
      if (c == rd) bv = rxb;
      if (samp && ts < 0) ts = c;
      if (bend) begin te = c; break; end
    end
  endtask

  task automatic cfg(input int b, input int s1, input int s2, input int j, input logic tr,
                     input int per);
    logic prev;
    int   c;
    @(negedge clk);
    req = 1'b1; prev = 1'b0;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk); #1;
      if (chg_en) break;
      prev = bend;
    end
    check(chg_en && prev, "R3 enable rise after boundary", int'(prev), 1);
    brp = 6'(b); t1 = 4'(s1); t2 = 3'(s2); sjw = 2'(j); tri_s = tr;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; req = 1'b0;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk); #1;
      if (!chg_en) break;
    end
    // cycle seen now is the first cycle of the first new bit
    c = 1;
    while (!bend && c < 5000) begin
      @(negedge clk); #1; c++;
    end
    check(c == per, "R5 first bit after enable falls", c, per);
  endtask

  int   ts, te;
  logic bv;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(chg_en == 1'b0, "R2 chg_en after reset", int'(chg_en), 0);
    check(rxb == 1'b1, "R2 rx_bit after reset", int'(rxb), 1);
    check(!samp && !bend, "R2 no strobe after reset", int'(samp | bend), 0);

    run_bit(0, 1, 0, 1, 0, 1, 0, ts, te, bv);
    check(te == 30, "R2 default bit length", te, 30);
    check(ts == 18, "R6 default sample point", ts, 18);

    for (int i = 0; i < NV; i++) begin
      int q, per;
      q   = VEC[i][0] + 1;
      per = q * (VEC[i][1] + VEC[i][2] + 3);
      cfg(VEC[i][0], VEC[i][1], VEC[i][2], 0, 1'b0, per);
      run_bit(0, 1, 0, 1, 0, 1, 0, ts, te, bv);
      check(te == per, "R1 bit length", te, per);
      check(ts == q * (VEC[i][1] + 2), "R6 sample point", ts, q * (VEC[i][1] + 2));
    end

    // R4: write while enable low, timing stays at brp=1 t1=2 t2=1
    @(negedge clk);
    brp = 6'd0; t1 = 4'd1; t2 = 3'd1; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    run_bit(0, 1, 0, 1, 0, 1, 0, ts, te, bv);
    check(te == 12, "R4 ignored write bit length", te, 12);
    check(ts == 8, "R4 ignored write sample point", ts, 8);

    // sampling: brp=3, 4 cycles per quantum, sample tick at cycle 24
    cfg(3, 4, 3, 0, 1'b0, 40);
    run_bit(1, 1'b0, 21, 1'b1, 0, 1, 25, ts, te, bv);
    check(bv == 1'b1, "R7 single sample value", int'(bv), 1);
    check(te == 40, "R11 edge in sync ignored", te, 40);
    cfg(3, 4, 3, 0, 1'b1, 40);
    run_bit(1, 1'b0, 21, 1'b1, 0, 1, 25, ts, te, bv);
    check(bv == 1'b0, "R8 majority 0,0,1", int'(bv), 0);
    check(te == 40, "R11 edge in sync ignored triple", te, 40);
    run_bit(1, 1'b0, 17, 1'b1, 0, 1, 25, ts, te, bv);
    check(bv == 1'b1, "R8 majority 0,1,1", int'(bv), 1);

    // resync: brp=0, one cycle per quantum, nominal 10 cycles
    cfg(0, 4, 3, 1, 1'b0, 10);
    run_bit(4, 1'b0, 0, 1, 0, 1, 0, ts, te, bv); rx = 1'b1;
    check(te == 12, "R9 late edge sjw=1", te, 12);
    run_bit(8, 1'b0, 0, 1, 0, 1, 0, ts, te, bv); rx = 1'b1;
    check(te == 8, "R10 early edge sjw=1", te, 8);
    run_bit(4, 1'b0, 5, 1'b1, 6, 1'b0, 0, ts, te, bv); rx = 1'b1;
    check(te == 12, "R11 one resync per bit", te, 12);
    cfg(0, 4, 3, 0, 1'b0, 10);
    run_bit(4, 1'b0, 0, 1, 0, 1, 0, ts, te, bv); rx = 1'b1;
    check(te == 11, "R9 late edge limited by sjw=0", te, 11);
    run_bit(8, 1'b0, 0, 1, 0, 1, 0, ts, te, bv); rx = 1'b1;
    check(te == 9, "R10 early edge limited by sjw=0", te, 9);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule